// File: doc/BRIEF.md
# Program Memory Byte Fetch Unit

This block sits between an execution pipeline and a program memory that is a whole number of bytes wide (two by default). It serves two kinds of access through a byte pointer, called Z here. Z is supplied as two register-file bytes: `z_hi` is the upper byte and `z_lo` is the lower byte. A byte load splits Z into a word address and a byte-lane select. It reads the word, returns the chosen byte and, in its incrementing form, hands back Z advanced by one. A word store writes a whole word at the word address held in Z and, in its incrementing form, hands back Z advanced by one word.

A request is accepted in the idle state when `op_valid` is high and `op_code` holds a known code. The unit then walks three states. `ST_IDLE` moves to `ST_ACCESS` on an accepted request and otherwise stays where it is. `ST_ACCESS` drives the memory address together with a read or a write strobe for exactly one cycle, and always moves to `ST_RESULT`. `ST_RESULT` presents the loaded byte, the write-back bytes for Z and the alignment flag for one cycle, and always returns to `ST_IDLE`. The memory answers a read one cycle after the strobe. Every access uses the Z value captured at acceptance, which is the value before any increment. The new Z bytes are offered in the same cycle as the result.

Top module: `pmem_byte_fetch`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_rd_en`, `mem_wr_en`, `done`, `rd_valid`, `z_wb_en` and `align_err` are all 0, and no memory strobe is ever raised while `busy` is 0.
- R2: A load (op_code 1 = plain load, 2 = load with increment) raises `mem_rd_en` for exactly one cycle, the cycle after acceptance. In that cycle `mem_addr` equals Z shifted right by one, that is Z[15:1].
- R3: In the result cycle `rd_valid` is 1 and `rd_byte` equals `mem_rdata[7:0]` when Z bit 0 is 0, or `mem_rdata[15:8]` when Z bit 0 is 1.
- R4: A load with increment raises `z_wb_en` in the result cycle, with {`z_hi_new`,`z_lo_new`} = (Z + 1) mod 65536, so 16'hFFFF wraps to 0.
- R5: A plain load (code 1) or a plain store (code 3) leaves `z_wb_en` at 0.
- R6: A store (op_code 3 = plain store, 4 = store with increment) raises `mem_wr_en` for exactly one cycle, the cycle after acceptance. In that cycle `mem_addr` = Z[15:1] and `mem_wdata` equals the `st_word` captured at acceptance, and `mem_rd_en` stays 0.
- R7: A store with increment raises `z_wb_en` in the result cycle, with {`z_hi_new`,`z_lo_new`} = (Z + 2) mod 65536, computed from the Z given with the request.
- R8: A store whose Z bit 0 is 1 raises `align_err` in its result cycle and still writes at Z[15:1], so bit 0 is treated as 0 for the access. Loads and aligned stores never raise `align_err`.
- R9: The access uses the Z captured at acceptance. Changes on `z_hi`/`z_lo`/`st_word` after acceptance do not alter `mem_addr`, `mem_wdata` or the write-back value.
- R10: `op_valid` is ignored while `busy` is 1, and it is ignored together with any op_code outside 1..4. An ignored request raises no strobe and does not set `busy`.
- R11: `done` is 1 for exactly the result cycle, which is the second cycle after acceptance, and `busy` is 1 in both the access cycle and the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe, taken only in the idle state |
| op_code | input | 3 | 1 load, 2 load with increment, 3 store, 4 store with increment |
| z_hi | input | 8 | Upper byte of Z |
| z_lo | input | 8 | Lower byte of Z |
| st_word | input | 16 | Word to store |
| mem_rdata | input | 16 | Read word, valid one cycle after `mem_rd_en` |
| busy | output | 1 | Request in flight |
| mem_addr | output | 15 | Word address |
| mem_rd_en | output | 1 | Read strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write word |
| rd_byte | output | 8 | Selected byte of a load |
| rd_valid | output | 1 | `rd_byte` valid |
| done | output | 1 | Result cycle |
| z_wb_en | output | 1 | Write back the new Z bytes |
| z_hi_new | output | 8 | New upper byte of Z |
| z_lo_new | output | 8 | New lower byte of Z |
| align_err | output | 1 | Store issued with Z bit 0 set |

## Verification
The assertions assume the memory returns the read word exactly one cycle after `mem_rd_en`, and that `op_valid` and `op_code` change only between clock edges. They also assume that a request's Z and store word are settled in the cycle it is accepted. The bench's memory model answers with a fixed one-cycle delay. The bench drives every input half a cycle away from the rising edge, and it scrambles Z and the store word right after acceptance, so an access that used the live inputs instead of the captured ones would be caught.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LD     = 3'd1,
        OP_LD_INC = 3'd2,
        OP_ST     = 3'd3,
        OP_ST_INC = 3'd4
    } pmf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_RESULT = 2'd2
    } pmf_state_e;

endpackage

// File: rtl/pmf_lane_sel.sv
module pmf_lane_sel #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] lane_w [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_w[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane_w[sel_i];

endmodule

// File: rtl/pmf_zstep.sv
module pmf_zstep #(
    parameter int ZW    = 16,
    parameter int LANES = 2
) (
    input  logic [ZW-1:0] z_i,
    input  logic          word_step_i,
    output logic [ZW-1:0] z_o
);

    localparam logic [ZW-1:0] BYTE_STEP = ZW'(1);
    localparam logic [ZW-1:0] WORD_STEP = ZW'(LANES);

    // Wraps naturally modulo 2^ZW.
    assign z_o = z_i + (word_step_i ? WORD_STEP : BYTE_STEP);

endmodule

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
    import pmf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [2:0] op_code,
    output logic       accept,
    output logic       busy,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic       result,
    output logic       q_load,
    output logic       q_store,
    output logic       q_inc
);

    pmf_state_e state_q, state_d;
    logic [2:0] op_q;
    logic       known;

    assign known  = (op_code == OP_LD) || (op_code == OP_LD_INC) ||
                    (op_code == OP_ST) || (op_code == OP_ST_INC);
    assign accept = (state_q == ST_IDLE) && op_valid && known;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_RESULT;
            ST_RESULT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
        end else begin
            state_q <= state_d;
            if (accept) op_q <= op_code;
        end
    end

    assign q_load  = (op_q == OP_LD) || (op_q == OP_LD_INC);
    assign q_store = (op_q == OP_ST) || (op_q == OP_ST_INC);
    assign q_inc   = (op_q == OP_LD_INC) || (op_q == OP_ST_INC);

    always_comb begin
        busy      = 1'b0;
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        result    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCESS: begin
                busy      = 1'b1;
                rd_strobe = q_load;
                wr_strobe = q_store;
            end
            ST_RESULT: begin
                busy   = 1'b1;
                result = 1'b1;
            end
            default: ;
        endcase
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(rd_strobe || wr_strobe));

    assert_strobe_then_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |=> (result && busy));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |-> !accept);

endmodule

// File: rtl/pmem_byte_fetch.sv
module pmem_byte_fetch
    import pmf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int ZW     = 2 * BYTE_W,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int SEL_W  = $clog2(LANES),
    localparam int WA_W   = ZW - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [BYTE_W-1:0] z_hi,
    input  logic [BYTE_W-1:0] z_lo,
    input  logic [WORD_W-1:0] st_word,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic [WA_W-1:0]   mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              rd_valid,
    output logic              done,
    output logic              z_wb_en,
    output logic [BYTE_W-1:0] z_hi_new,
    output logic [BYTE_W-1:0] z_lo_new,
    output logic              align_err
);

    logic              accept, result, q_load, q_store, q_inc;
    logic [ZW-1:0]     z_q, z_next;
    logic [WORD_W-1:0] w_q;
    logic [BYTE_W-1:0] lane_byte;

    pmf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .accept    (accept),
        .busy      (busy),
        .rd_strobe (mem_rd_en),
        .wr_strobe (mem_wr_en),
        .result    (result),
        .q_load    (q_load),
        .q_store   (q_store),
        .q_inc     (q_inc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= '0;
            w_q <= '0;
        end else if (accept) begin
            z_q <= {z_hi, z_lo};
            w_q <= st_word;
        end
    end

    pmf_lane_sel #(.BYTE_W(BYTE_W), .LANES(LANES)) u_lane (
        .word_i (mem_rdata),
        .sel_i  (z_q[SEL_W-1:0]),
        .byte_o (lane_byte)
    );

    pmf_zstep #(.ZW(ZW), .LANES(LANES)) u_step (
        .z_i         (z_q),
        .word_step_i (q_store),
        .z_o         (z_next)
    );

    // Word address drops the lane bits, so a store is forced to lane 0.
    assign mem_addr  = z_q[ZW-1:SEL_W];
    assign mem_wdata = w_q;
    assign done      = result;
    assign rd_valid  = result && q_load;
    assign rd_byte   = rd_valid ? lane_byte : '0;
    assign z_wb_en   = result && q_inc;
    assign z_hi_new  = z_next[ZW-1:BYTE_W];
    assign z_lo_new  = z_next[BYTE_W-1:0];
    assign align_err = result && q_store && (|z_q[SEL_W-1:0]);

    assert_addr_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (mem_addr == $past(z_hi_lo_w[ZW-1:SEL_W])));

    logic [ZW-1:0] z_hi_lo_w;
    assign z_hi_lo_w = {z_hi, z_lo};

    assert_load_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_LD_INC) |-> ##2
        (z_wb_en && {z_hi_new, z_lo_new} == $past(z_hi_lo_w, 2) + ZW'(1)));

    assert_store_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == OP_ST_INC) |-> ##2
        (z_wb_en && {z_hi_new, z_lo_new} == $past(z_hi_lo_w, 2) + ZW'(LANES)));

    assert_plain_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_code == OP_LD || op_code == OP_ST)) |-> ##2 !z_wb_en);

    assert_err_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> $past(mem_wr_en));

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en && !mem_rd_en);

endmodule

// File: tb/tb_pmem_byte_fetch.sv
module tb_pmem_byte_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  z_hi = 8'd0, z_lo = 8'd0;
    logic [15:0] st_word = 16'd0;
    logic [15:0] mem_rdata = 16'd0;
    logic        busy, mem_rd_en, mem_wr_en, rd_valid, done, z_wb_en, align_err;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [7:0]  rd_byte, z_hi_new, z_lo_new;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pmem_byte_fetch dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .z_hi(z_hi), .z_lo(z_lo), .st_word(st_word), .mem_rdata(mem_rdata),
        .busy(busy), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .rd_byte(rd_byte),
        .rd_valid(rd_valid), .done(done), .z_wb_en(z_wb_en),
        .z_hi_new(z_hi_new), .z_lo_new(z_lo_new), .align_err(align_err)
    );

    function automatic logic [15:0] pattern(input logic [14:0] a);
        return {a[7:0] + 8'h3C, a[14:7] ^ 8'hA5};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= pattern(mem_addr);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] code, input logic [15:0] z,
                          input logic [15:0] w);
        logic ld, st, inc;
        logic [15:0] step, ev;
        ld  = (code == 3'd1) || (code == 3'd2);
        st  = (code == 3'd3) || (code == 3'd4);
        inc = (code == 3'd2) || (code == 3'd4);
        step = st ? 16'd2 : 16'd1;
        @(negedge clk);
        op_valid = 1'b1; op_code = code;
        z_hi = z[15:8]; z_lo = z[7:0]; st_word = w;
        @(negedge clk);
        op_valid = 1'b0; z_hi = ~z[15:8]; z_lo = z[7:0] ^ 8'h5B; st_word = ~w;
        check("R11", "busy in access", {31'd0, busy}, 32'd1);
        check("R11", "done in access", {31'd0, done}, 32'd0);
        check(ld ? "R2" : "R6", "read strobe", {31'd0, mem_rd_en}, {31'd0, ld});
        check(st ? "R6" : "R2", "write strobe", {31'd0, mem_wr_en}, {31'd0, st});
        check("R9", "address", {17'd0, mem_addr}, {17'd0, z[15:1]});
        if (st) check("R6", "write data", {16'd0, mem_wdata}, {16'd0, w});
        @(negedge clk);
        check("R11", "done in result", {31'd0, done}, 32'd1);
        check("R2", "no strobe in result", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
        check("R3", "rd_valid", {31'd0, rd_valid}, {31'd0, ld});
        if (ld) begin
            ev = pattern(z[15:1]);
            check("R3", "byte lane", {24'd0, rd_byte},
                  {24'd0, z[0] ? ev[15:8] : ev[7:0]});
        end
        check(inc ? (st ? "R7" : "R4") : "R5", "z_wb_en", {31'd0, z_wb_en}, {31'd0, inc});
        if (inc) check(st ? "R7" : "R4", "new Z", {16'd0, z_hi_new, z_lo_new},
                       {16'd0, z + step});
        check("R8", "align_err", {31'd0, align_err}, {31'd0, st && z[0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset outputs",
              {25'd0, busy, mem_rd_en, mem_wr_en, done, rd_valid, z_wb_en, align_err}, 32'd0);

        for (int i = 0; i < 2048; i++) begin
            logic [15:0] z;
            z = 16'(i * 16'd61) ^ 16'(i >> 3);
            run_op(3'(1 + (i % 4)), z, 16'(i * 16'h9E37));
        end

        run_op(3'd2, 16'hFFFF, 16'h0);   // R4 wrap to 0
        run_op(3'd4, 16'hFFFE, 16'h1234); // R7 wrap to 0
        run_op(3'd4, 16'hFFFF, 16'h4321); // R8 misaligned, R7 gives 0001
        run_op(3'd3, 16'h0101, 16'hBEEF); // R8 misaligned plain store
        run_op(3'd1, 16'h0000, 16'h0);
        run_op(3'd1, 16'h0001, 16'h0);

        // R10: request while busy is ignored
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; z_hi = 8'h12; z_lo = 8'h34;
        @(negedge clk);
        op_code = 3'd4; z_hi = 8'h55; z_lo = 8'h66;
        check("R10", "access while request held", {31'd0, mem_rd_en}, 32'd1);
        @(negedge clk);
        op_valid = 1'b0;
        check("R10", "result of first op", {31'd0, z_wb_en}, 32'd0);
        @(negedge clk);
        check("R10", "held request not taken", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check("R10", "no late strobe", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);

        // R10: unknown codes ignored
        for (int c = 0; c < 8; c++) begin
            if (c >= 1 && c <= 4) continue;
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'(c);
            @(negedge clk);
            op_valid = 1'b0;
            check("R10", "unknown code busy", {31'd0, busy}, 32'd0);
            check("R1", "unknown code strobes", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule